// File: doc/BRIEF.md
# Write Burst Scheduler with Precharge Cut-Off

This block sits on the controller side of a DDR SDRAM interface. It turns write and precharge requests into a registered command stream and the per-cycle write-strobe controls. Each write carries a bank, a column and a full burst of eight data beats. The block launches the burst and then enforces write recovery before it lets a precharge out. All timing is counted in the command clock domain.

A precharge addressed to the bank that is writing may cut the burst short. From that point on, the remaining beats are sent with the data mask asserted while DQS keeps running. The precharge then leaves once the recovery count has elapsed from the last unmasked data. A precharge to any other bank waits until the burst has finished and its recovery has run out. A fresh write can be chained directly after the last data cycle of the previous one. This gives gapless random column access within the open row.

Cycle numbering used below: cycle 0 is the cycle in which WRITE appears on the outputs. A request held high during cycle n-1 is seen at the clock edge that starts cycle n. TWR is a parameter counted in clock cycles.

Top module: `wrPrechargeSched`

## Requirements
- R1: Command encoding on `cmdOut` is 0 = NOP, 1 = WRITE, 2 = PRECHARGE. During and right after reset, `cmdOut`, `cmdBank`, `cmdCol`, `dqsEn`, `dmOut`, `dqValid` and `busy` are all zero.
- R2: In cycle 0, `cmdBank` and `cmdCol` hold the requested bank and column, and `dqsEn` is high as a one-cycle preamble. In cycles 1 to 4 each cycle carries two beats with `dqValid` high and `dmOut` = 00. `dqOut` bits [DQ_W-1:0] hold beat 2(n-1) and the upper half holds beat 2(n-1)+1. Beat j of `wrData` sits at bits [j*DQ_W +: DQ_W].
- R3: With no interruption, a precharge to the writing bank is issued no earlier than cycle 5+TWR. If it is already pending by then, it is issued in exactly that cycle.
- R4: A precharge to the writing bank that is first seen at the start of data cycle k (1 to 4) masks cycle k and every later data cycle before the precharge. Masked cycles have `dmOut` = 11, `dqValid` low and `dqsEn` high. The precharge is issued in cycle k+TWR, and no data cycle occurs in or after that cycle.
- R5: A precharge to a different bank, requested during a burst, neither masks nor shortens it. It is issued in cycle 5+TWR and carries its own bank on `cmdBank`.
- R6: `busy` is high from cycle 0 up to the cycle before the precharge, or up to cycle 4+TWR when no precharge follows. It is low in the precharge cycle.
- R7: When the block is idle, a precharge request is issued in the cycle after it is seen, with `busy` staying low.
- R8: A write request seen at the end of the last data cycle, with no precharge pending, issues the next WRITE in cycle 5. `dqsEn` stays high without a gap, and the new data starts in cycle 6.
- R9: Every cycle that carries no command shows NOP. The precharge cycle carries no valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrReq | input | 1 | Write request, held until WRITE appears on `cmdOut` |
| wrBank | input | BANK_W | Bank of the requested write |
| wrCol | input | COL_W | Column of the requested write |
| wrData | input | BURST_LEN*DQ_W | Burst data, beat j at [j*DQ_W +: DQ_W] |
| preReq | input | 1 | Precharge request, held until PRECHARGE appears on `cmdOut` |
| preBank | input | BANK_W | Bank to precharge |
| cmdOut | output | 2 | Command: 0 NOP, 1 WRITE, 2 PRECHARGE |
| cmdBank | output | BANK_W | Bank of the current command |
| cmdCol | output | COL_W | Column of the current WRITE |
| dqsEn | output | 1 | Strobe enable, preamble and data cycles |
| dmOut | output | 2 | Data mask for the two beats of the cycle |
| dqOut | output | 2*DQ_W | Two data beats of the cycle |
| dqValid | output | 1 | Unmasked data present this cycle |
| busy | output | 1 | Burst or write recovery in progress |

## Verification
The hardest situation to reach from the ports is a same-bank precharge landing at one exact beat of a burst. The cut-off point, the length of the masked tail and the precharge cycle all depend on that alignment. The bench waits for WRITE to appear, then raises the precharge at each data offset in turn for every bank. It also runs the no-interrupt and other-bank cases. It compares every output cycle by cycle against arithmetic built from the offset and TWR. A separate sequence raises a second write exactly at the last data cycle to reach the gapless chain.

// File: rtl/wpsPkg.sv
package wpsPkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_PRE   = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WCMD,
    PH_DATA,
    PH_REC
  } phase_e;

  // strobes from control to datapath, valid for the next output cycle
  typedef struct packed {
    logic             issueWr;
    logic             issuePre;
    logic             dqsOn;
    logic             beatOn;
    logic             maskBeat;
    logic [SEL_W-1:0] beatSel;
  } strobe_t;
endpackage

// File: rtl/wpsControl.sv
module wpsControl
  import wpsPkg::*;
#(
  parameter int unsigned TWR    = 2,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned CYC    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              preReq,
  input  logic [BANK_W-1:0] preBank,
  input  logic [BANK_W-1:0] curBank,
  output strobe_t           stb,
  output logic              busy
);
  localparam int unsigned IDX_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int unsigned REC_W = $clog2(TWR + 2);

  phase_e           phase, nPhase;
  logic [IDX_W-1:0] idx, nIdx;
  logic             masked, nMask;
  logic [REC_W-1:0] recCnt, nRec, recNext;
  logic             sameBank, lastIdx, recDone;

  assign sameBank = preReq && (preBank == curBank);
  assign lastIdx  = (idx == IDX_W'(CYC - 1));
  assign recNext  = (recCnt >= REC_W'(TWR)) ? REC_W'(TWR) : recCnt + 1'b1;
  assign recDone  = (recNext >= REC_W'(TWR));
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    nPhase = phase;
    nIdx   = idx;
    nMask  = masked;
    nRec   = recCnt;
    stb    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (preReq) begin
          stb.issuePre = 1'b1;
        end else if (wrReq) begin
          stb.issueWr = 1'b1;
          stb.dqsOn   = 1'b1;
          nPhase      = PH_WCMD;
        end
      end
      PH_WCMD: begin
        nPhase      = PH_DATA;
        nIdx        = '0;
        stb.dqsOn   = 1'b1;
        stb.beatOn  = 1'b1;
        stb.beatSel = '0;
        nMask       = sameBank;
        nRec        = '0;
        stb.maskBeat = sameBank;
      end
      PH_DATA: begin
        if (masked) begin
          if (sameBank && recDone) begin
            stb.issuePre = 1'b1;
            nPhase       = PH_IDLE;
            nMask        = 1'b0;
          end else if (lastIdx) begin
            nPhase = PH_REC;
            nRec   = recNext;
            nMask  = 1'b0;
          end else begin
            nIdx         = idx + 1'b1;
            nRec         = recNext;
            stb.dqsOn    = 1'b1;
            stb.beatOn   = 1'b1;
            stb.maskBeat = 1'b1;
            stb.beatSel  = SEL_W'(idx + 1'b1);
          end
        end else if (lastIdx) begin
          if (!preReq && wrReq) begin
            stb.issueWr = 1'b1;
            stb.dqsOn   = 1'b1;
            nPhase      = PH_WCMD;
          end else begin
            nPhase = PH_REC;
            nRec   = '0;
          end
        end else begin
          nIdx         = idx + 1'b1;
          stb.dqsOn    = 1'b1;
          stb.beatOn   = 1'b1;
          stb.beatSel  = SEL_W'(idx + 1'b1);
          stb.maskBeat = sameBank;
          nMask        = sameBank;
          nRec         = '0;
        end
      end
      PH_REC: begin
        nRec = recNext;
        if (preReq && recDone) begin
          stb.issuePre = 1'b1;
          nPhase       = PH_IDLE;
        end else if (!preReq && wrReq) begin
          stb.issueWr = 1'b1;
          stb.dqsOn   = 1'b1;
          nPhase      = PH_WCMD;
        end else if (recDone) begin
          nPhase = PH_IDLE;
        end
      end
      default: nPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      masked <= 1'b0;
      recCnt <= '0;
    end else begin
      phase  <= nPhase;
      idx    <= nIdx;
      masked <= nMask;
      recCnt <= nRec;
    end
  end

  // R4: once masking has begun, only masked beats or a precharge may follow
  p_mask_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && masked && !lastIdx) |=> (phase == PH_DATA && masked) || phase == PH_IDLE);
  // R3: a precharge is never scheduled while unmasked burst data is still owed
  p_no_pre_mid_burst_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.issuePre |-> !(phase == PH_WCMD || (phase == PH_DATA && !masked)));
endmodule

// File: rtl/wpsDatapath.sv
module wpsDatapath
  import wpsPkg::*;
#(
  parameter int unsigned TWR       = 2,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DQ_W      = 8,
  parameter int unsigned BURST_LEN = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [BANK_W-1:0]         wrBank,
  input  logic [COL_W-1:0]          wrCol,
  input  logic [BURST_LEN*DQ_W-1:0] wrData,
  input  logic [BANK_W-1:0]         preBank,
  output logic [BANK_W-1:0]         curBank,
  output logic [1:0]                cmdOut,
  output logic [BANK_W-1:0]         cmdBank,
  output logic [COL_W-1:0]          cmdCol,
  output logic                      dqsEn,
  output logic [1:0]                dmOut,
  output logic [2*DQ_W-1:0]         dqOut,
  output logic                      dqValid
);
  localparam int unsigned CYC    = BURST_LEN / 2;
  localparam int unsigned IDX_W  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int unsigned PAIR_W = 2 * DQ_W;
  localparam int unsigned MARK_W = $clog2(TWR + 3);

  logic [BURST_LEN*DQ_W-1:0] burstData;
  logic [BANK_W-1:0]         burstBank;
  logic [PAIR_W-1:0]         pairs [CYC];
  logic [PAIR_W-1:0]         pairSel;

  for (genvar g = 0; g < CYC; g++) begin : g_pair
    assign pairs[g] = burstData[g*PAIR_W +: PAIR_W];
  end

  assign pairSel = pairs[stb.beatSel[IDX_W-1:0]];
  assign curBank = burstBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstData <= '0;
      burstBank <= '0;
      cmdOut    <= CMD_NOP;
      cmdBank   <= '0;
      cmdCol    <= '0;
      dqsEn     <= 1'b0;
      dmOut     <= '0;
      dqOut     <= '0;
      dqValid   <= 1'b0;
    end else begin
      if (stb.issueWr) begin
        burstData <= wrData;
        burstBank <= wrBank;
      end
      cmdOut  <= stb.issueWr ? CMD_WRITE : (stb.issuePre ? CMD_PRE : CMD_NOP);
      cmdBank <= stb.issueWr ? wrBank : (stb.issuePre ? preBank : '0);
      cmdCol  <= stb.issueWr ? wrCol : '0;
      dqsEn   <= stb.dqsOn;
      dqValid <= stb.beatOn && !stb.maskBeat;
      dmOut   <= (stb.beatOn && stb.maskBeat) ? 2'b11 : 2'b00;
      dqOut   <= (stb.beatOn && !stb.maskBeat) ? pairSel : '0;
    end
  end

  // port-level recovery watch: cycles since last valid data (or WRITE preamble)
  logic [MARK_W-1:0] sinceMark;
  logic              armed;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceMark <= '1;
      armed     <= 1'b0;
    end else begin
      if (dqValid || cmdOut == CMD_WRITE) sinceMark <= MARK_W'(1);
      else if (sinceMark != '1)           sinceMark <= sinceMark + 1'b1;
      if (cmdOut == CMD_WRITE)    armed <= 1'b1;
      else if (cmdOut == CMD_PRE) armed <= 1'b0;
    end
  end

  p_recovery_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_PRE && armed) |-> (sinceMark >= MARK_W'(TWR + 1)));
  p_mask_strobed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dmOut != 2'b00) |-> (dqsEn && !dqValid));
  p_preamble_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_WRITE) |-> dqsEn ##1 dqsEn);
  p_pre_no_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_PRE) |-> !dqValid);
endmodule

// File: rtl/wrPrechargeSched.sv
module wrPrechargeSched
  import wpsPkg::*;
#(
  parameter int unsigned TWR       = 2,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DQ_W      = 8,
  parameter int unsigned BURST_LEN = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrReq,
  input  logic [BANK_W-1:0]         wrBank,
  input  logic [COL_W-1:0]          wrCol,
  input  logic [BURST_LEN*DQ_W-1:0] wrData,
  input  logic                      preReq,
  input  logic [BANK_W-1:0]         preBank,
  output logic [1:0]                cmdOut,
  output logic [BANK_W-1:0]         cmdBank,
  output logic [COL_W-1:0]          cmdCol,
  output logic                      dqsEn,
  output logic [1:0]                dmOut,
  output logic [2*DQ_W-1:0]         dqOut,
  output logic                      dqValid,
  output logic                      busy
);
  localparam int unsigned CYC = BURST_LEN / 2;

  strobe_t           stb;
  logic [BANK_W-1:0] curBank;

  wpsControl #(.TWR(TWR), .BANK_W(BANK_W), .CYC(CYC)) ctl_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .preReq(preReq),
    .preBank(preBank), .curBank(curBank), .stb(stb), .busy(busy)
  );

  wpsDatapath #(.TWR(TWR), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
                .BURST_LEN(BURST_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBank(wrBank), .wrCol(wrCol),
    .wrData(wrData), .preBank(preBank), .curBank(curBank), .cmdOut(cmdOut),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .dqsEn(dqsEn), .dmOut(dmOut),
    .dqOut(dqOut), .dqValid(dqValid)
  );

  // R6: busy can only start together with a WRITE
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cmdOut == 2'd1));
endmodule

// File: tb/wrPrechargeSched_tb_top.sv
module wrPrechargeSched_tb_top;
  localparam int TWR = 2;
  localparam int BW  = 2;
  localparam int CW  = 10;
  localparam int DW  = 8;
  localparam int BL  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0;
  logic [BW-1:0] wrBank = '0;
  logic [CW-1:0] wrCol = '0;
  logic [BL*DW-1:0] wrData = '0;
  logic preReq = 1'b0;
  logic [BW-1:0] preBank = '0;
  logic [1:0] cmdOut;
  logic [BW-1:0] cmdBank;
  logic [CW-1:0] cmdCol;
  logic dqsEn;
  logic [1:0] dmOut;
  logic [2*DW-1:0] dqOut;
  logic dqValid;
  logic busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wrPrechargeSched #(.TWR(TWR), .BANK_W(BW), .COL_W(CW), .DQ_W(DW), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrBank(wrBank), .wrCol(wrCol),
    .wrData(wrData), .preReq(preReq), .preBank(preBank), .cmdOut(cmdOut),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .dqsEn(dqsEn), .dmOut(dmOut),
    .dqOut(dqOut), .dqValid(dqValid), .busy(busy)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat(input int b, input int k, input int j);
    return DW'((b << 6) | (k << 3) | j);
  endfunction

  function automatic logic [BL*DW-1:0] burst(input int b, input int k);
    logic [BL*DW-1:0] v = '0;
    for (int j = 0; j < BL; j++) v[j*DW +: DW] = beat(b, k, j);
    return v;
  endfunction

  // k = 1..4 interrupt offset, k = 5 no interrupt; other = precharge to another bank
  task automatic runBurst(input int b, input int k, input bit other);
    int p, vEnd, n;
    logic [BW-1:0] pb;
    logic [1:0] eCmd, eDm;
    logic eDqs, eVal, eBusy;
    string req;
    p    = (other || k == 5) ? 5 + TWR : k + TWR;
    vEnd = other ? 5 : k;
    pb   = other ? BW'(b ^ 1) : BW'(b);
    req  = other ? "R5" : ((k == 5) ? "R3" : "R4");
    @(negedge clk);
    wrReq = 1'b1; wrBank = BW'(b); wrCol = CW'(b * 16 + k); wrData = burst(b, k);
    n = 0;
    do begin @(negedge clk); n++; end while (cmdOut != 2'd1 && n < 20);
    for (int t = 0; t <= p + 1; t++) begin
      if (t > 0) @(negedge clk);
      eCmd  = (t == 0) ? 2'd1 : ((t == p) ? 2'd2 : 2'd0);
      eDqs  = (t == 0) || (t >= 1 && t <= 4 && t < p);
      eVal  = (t >= 1 && t <= 4 && t < vEnd);
      eDm   = (t >= 1 && t <= 4 && t >= vEnd && t < p) ? 2'b11 : 2'b00;
      eBusy = (t < p);
      check(req, $sformatf("b%0d k%0d t%0d cmd/dqs/dm/val", b, k, t),
            64'({cmdOut, dqsEn, dmOut, dqValid}), 64'({eCmd, eDqs, eDm, eVal}));
      check("R6", $sformatf("b%0d k%0d t%0d busy", b, k, t), 64'(busy), 64'(eBusy));
      if (eVal)
        check("R2", $sformatf("b%0d k%0d t%0d data", b, k, t), 64'(dqOut),
              64'({beat(b, k, 2*t-1), beat(b, k, 2*t-2)}));
      if (t == 0)
        check("R2", "write bank/col", 64'({cmdBank, cmdCol}), 64'({BW'(b), CW'(b*16+k)}));
      if (t == p)
        check(req, "precharge bank", 64'(cmdBank), 64'(pb));
      if (t == 0) wrReq = 1'b0;
      if (t == k - 1 || (k == 5 && t == 4)) begin preReq = 1'b1; preBank = pb; end
      if (t == p) preReq = 1'b0;
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", 64'({cmdOut, cmdBank, cmdCol, dqsEn, dmOut, dqOut, dqValid, busy}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", 64'({cmdOut, dqsEn, busy}), 64'(0));

    for (int b = 0; b < 4; b++) begin
      for (int k = 1; k <= 5; k++) runBurst(b, k, 1'b0);
      for (int k = 1; k <= 4; k++) runBurst(b, k, 1'b1);
    end

    // R7: precharge while idle
    repeat (4) @(negedge clk);
    preReq = 1'b1; preBank = 2'd3;
    @(negedge clk);
    check("R7", "idle precharge cmd/bank/busy", 64'({cmdOut, cmdBank, busy}), 64'({2'd2, 2'd3, 1'b0}));
    preReq = 1'b0;
    @(negedge clk);
    check("R9", "NOP after precharge", 64'(cmdOut), 64'(0));

    // R8: back-to-back write at the last data cycle
    wrReq = 1'b1; wrBank = 2'd1; wrCol = 10'd100; wrData = burst(1, 6);
    n = 0;
    do begin @(negedge clk); n++; end while (cmdOut != 2'd1 && n < 20);
    wrReq = 1'b0;
    for (int t = 1; t <= 6; t++) begin
      @(negedge clk);
      if (t == 4) begin wrReq = 1'b1; wrCol = 10'd200; wrData = burst(1, 7); end
      if (t == 5) begin
        check("R8", "second WRITE cmd/col", 64'({cmdOut, cmdCol}), 64'({2'd1, 10'd200}));
        wrReq = 1'b0;
      end
      if (t >= 4) check("R8", $sformatf("t%0d dqs continuous", t), 64'(dqsEn), 64'(1));
      if (t == 6)
        check("R8", "second burst first data", 64'({dqValid, dqOut}),
              64'({1'b1, beat(1, 7, 1), beat(1, 7, 0)}));
    end
    repeat (12) @(negedge clk);
    check("R6", "idle after chained bursts", 64'({busy, cmdOut}), 64'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule